// File: doc/BRIEF.md
# Hashed Page Table Walker

This block runs after block translation has missed. It searches a hashed page table held in memory for the entry that maps one 4 KiB page. It takes a virtual segment ID, the offset of the access within its 256 MiB segment, and the base and size mask of the table. From these it forms a hash and visits the eight entries of one group. If no entry matches, it visits a second group addressed by the complemented hash. Memory is reached through a port that reads one 32-bit word at a time and writes single bytes, and every transaction completes on a ready handshake.

Once an entry is found, the walker reports the entry address, both entry words and the real address. A permission decision made outside the block arrives as a grant level. If the grant is high, the walker writes back the referenced flag and, for stores, the changed flag, one byte each. A load that sees the changed flag clear sets a write-revoke output, so that a later store comes back through the walker.

The controller has seven states:
- ST_IDLE waits for a request and goes to ST_RD0.
- ST_RD0 reads word 0 of the current entry. It goes to ST_RD1 on a match, stays in ST_RD0 for the next entry or the other group, and goes to ST_DONE after the last entry of the secondary group.
- ST_RD1 reads word 1 and goes to ST_CHECK.
- ST_CHECK samples the grant. It goes to ST_SETR, ST_SETC or ST_DONE.
- ST_SETR writes the referenced byte and goes to ST_SETC or ST_DONE.
- ST_SETC writes the changed byte and goes to ST_DONE.
- ST_DONE pulses done for one cycle and returns to ST_IDLE.

Top module: `hpt_walker`

## Requirements
- R1: After reset, done, found, mem_rd and mem_wr are 0. A request is taken only in ST_IDLE. A req pulse during a walk starts no second walk and produces no second done.
- R2: The primary hash is {8'b0,vsid} XOR {16'b0,seg_ofs[27:12]}. The group address is tbl_base + ((hash << 6) AND tbl_mask). The first read of a walk is at that address.
- R3: Entries are 8 bytes and tbl_base is 8-byte aligned. Entry k of a group is at group address + 8k, and entries are read in order k = 0 to 7. Word 0 has valid in bit 31, the segment ID in bits 30:7, the hash-select flag in bit 6, and the page tag in bits 5:0. The page tag must equal seg_ofs[27:22].
- R4: If the primary group has no match, the secondary group at ((~hash) << 6) AND tbl_mask is searched. An entry matches only if it is valid, its segment ID and tag are equal, and its hash-select flag is 0 in the primary pass and 1 in the secondary pass. An entry whose flag does not fit the pass is skipped.
- R5: Word 0 of an entry is read before word 1. Word 1 is read at entry + 4, and only when word 0 matches. Memory words are big-endian.
- R6: When neither group matches, done rises with found = 0 after exactly 16 word-0 reads and no writes.
- R7: With grant high and word 1 bit 8 (referenced) clear, one byte is written at entry + 6 with the value word1[15:8] OR 0x01.
- R8: With grant high, a store, and word 1 bit 7 (changed) clear, one byte is written at entry + 7 with the value word1[7:0] OR 0x80. When both bytes are written, the referenced byte comes first.
- R9: When word 1 bit 7 is clear on a non-store access, the changed byte is not written and wr_revoke is 1 while done is high.
- R10: With grant low, a found entry is reported with found = 1 and no byte is written.
- R11: With done and found high, real_addr = {word1[31:12], seg_ofs[11:0]}, pte_addr is the matching entry address, and pte_w0 and pte_w1 are the words that were read.
- R12: A read or write strobe and its address are held until mem_ready. mem_rd and mem_wr are never both high. done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start strobe, taken in idle |
| seg_ofs | input | 28 | Effective address within the segment |
| vsid | input | 24 | Virtual segment ID |
| tbl_base | input | 32 | Table base byte address |
| tbl_mask | input | 32 | Table size mask for group offsets |
| is_store | input | 1 | Access is a store |
| grant | input | 1 | External permission result, sampled in ST_CHECK |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | 32 | Byte address of transaction |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 32 | Read word, valid with mem_ready |
| mem_ready | input | 1 | Transaction complete |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | Entry located |
| pte_addr | output | 32 | Address of the matching entry |
| pte_w0 | output | 32 | Entry word 0 as read |
| pte_w1 | output | 32 | Entry word 1 as read |
| real_addr | output | 32 | Real page number joined with the page offset |
| wr_revoke | output | 1 | Write permission withdrawn until the changed flag is set |

## Verification
The hardest case to reach from the ports is a secondary-pass hit. It needs a primary group full of entries that almost match: one carries the right tag with the wrong hash-select flag, and another differs only in its page tag. The secondary group must also hold a decoy with the flag clear ahead of the real entry. The bench builds these groups in its memory model from the hash formula, and it counts both the reads and the addresses they go to. A second hard case is a req pulse during a full miss walk. That is a 16-read search with varying ready latency, and the bench confirms that nothing follows the single done.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    localparam int ENTRY_BYTES = 8;
    localparam int ENT_SHIFT   = 3;
    localparam int W1_OFS      = 4;
    localparam int RBYTE_OFS   = 6;
    localparam int CBYTE_OFS   = 7;
    localparam int VSID_W      = 24;
    localparam int TAG_W       = VSID_W + 6;
    localparam int V_BIT       = 31;
    localparam int H_BIT       = 6;
    localparam int REF_BIT     = 8;
    localparam int CHG_BIT     = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_CHECK,
        ST_SETR,
        ST_SETC,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [15:0]       pg_idx,
    input  logic [31:0]       tbl_mask,
    input  logic              pass,
    output logic [31:0]       grp_off,
    output logic [TAG_W-1:0]  tag
);
    localparam int GRP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);

    logic [31:0] hash_w;
    logic [31:0] sel_w;

    assign hash_w  = {8'b0, vsid} ^ {16'b0, pg_idx};
    // the secondary pass indexes with the complemented hash
    assign sel_w   = pass ? ~hash_w : hash_w;
    assign grp_off = (sel_w << GRP_SHIFT) & tbl_mask;
    assign tag     = {vsid, pg_idx[15:10]};
endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic [31:0]      w0,
    input  logic [TAG_W-1:0] tag,
    input  logic             pass,
    output logic             hit
);
    assign hit = w0[V_BIT] && (w0[H_BIT] == pass) &&
                 (w0[30:7] == tag[TAG_W-1:6]) && (w0[5:0] == tag[5:0]);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [27:0]       seg_ofs,
    input  logic [VSID_W-1:0] vsid,
    input  logic [31:0]       tbl_base,
    input  logic [31:0]       tbl_mask,
    input  logic              is_store,
    input  logic              grant,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              found,
    output logic [31:0]       pte_addr,
    output logic [31:0]       pte_w0,
    output logic [31:0]       pte_w1,
    output logic [31:0]       real_addr,
    output logic              wr_revoke
);
    localparam int IDX_W = $clog2(GROUP_ENTRIES);

    walk_st_e          state_q, state_d;
    logic [27:0]       ofs_q;
    logic [VSID_W-1:0] vsid_q;
    logic [31:0]       base_q, mask_q;
    logic              store_q, pass_q, found_q;
    logic [IDX_W-1:0]  idx_q;
    logic [31:0]       w0_q, w1_q;
    logic [31:0]       grp_off, entry_addr;
    logic [TAG_W-1:0]  tag;
    logic              hit, last_idx, need_c;

    hpt_hash #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_hash (
        .vsid    (vsid_q),
        .pg_idx  (ofs_q[27:12]),
        .tbl_mask(mask_q),
        .pass    (pass_q),
        .grp_off (grp_off),
        .tag     (tag)
    );

    hpt_match u_match (
        .w0  (mem_rdata),
        .tag (tag),
        .pass(pass_q),
        .hit (hit)
    );

    assign entry_addr = base_q + grp_off + (32'(idx_q) << ENT_SHIFT);
    assign last_idx   = (idx_q == IDX_W'(GROUP_ENTRIES - 1));
    assign need_c     = !w1_q[CHG_BIT] && store_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q   <= '0;
            vsid_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            store_q <= 1'b0;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            w0_q    <= '0;
            w1_q    <= '0;
            found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req) begin
                    ofs_q   <= seg_ofs;
                    vsid_q  <= vsid;
                    base_q  <= tbl_base;
                    mask_q  <= tbl_mask;
                    store_q <= is_store;
                    pass_q  <= 1'b0;
                    idx_q   <= '0;
                    found_q <= 1'b0;
                end
                ST_RD0: if (mem_ready) begin
                    w0_q <= mem_rdata;
                    if (!hit) begin
                        if (!last_idx) begin
                            idx_q <= idx_q + 1'b1;
                        end else if (!pass_q) begin
                            idx_q  <= '0;
                            pass_q <= 1'b1;
                        end
                    end
                end
                ST_RD1: if (mem_ready) begin
                    w1_q    <= mem_rdata;
                    found_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // next state and memory port
    always_comb begin
        state_d   = state_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = entry_addr;
        mem_wdata = 8'h00;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_RD0;
            ST_RD0: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    if (hit)                   state_d = ST_RD1;
                    else if (last_idx && pass_q) state_d = ST_DONE;
                end
            end
            ST_RD1: begin
                mem_rd   = 1'b1;
                mem_addr = entry_addr + 32'(W1_OFS);
                if (mem_ready) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (!grant)              state_d = ST_DONE;
                else if (!w1_q[REF_BIT]) state_d = ST_SETR;
                else if (need_c)         state_d = ST_SETC;
                else                     state_d = ST_DONE;
            end
            ST_SETR: begin
                mem_wr    = 1'b1;
                mem_addr  = entry_addr + 32'(RBYTE_OFS);
                mem_wdata = w1_q[15:8] | 8'h01;
                if (mem_ready) state_d = need_c ? ST_SETC : ST_DONE;
            end
            ST_SETC: begin
                mem_wr    = 1'b1;
                mem_addr  = entry_addr + 32'(CBYTE_OFS);
                mem_wdata = w1_q[7:0] | 8'h80;
                if (mem_ready) state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign found     = found_q;
    assign pte_addr  = entry_addr;
    assign pte_w0    = w0_q;
    assign pte_w1    = w1_q;
    assign real_addr = {w1_q[31:12], ofs_q[11:0]};
    assign wr_revoke = found_q && !w1_q[CHG_BIT] && !store_q;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        is_store,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        done
);
    p_rdwr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) && !mem_ready |=> (mem_rd || mem_wr) && $stable(mem_addr));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ref_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && (mem_addr[2:0] == 3'd6) |-> mem_wdata[0]);

    p_chg_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && (mem_addr[2:0] == 3'd7) |-> mem_wdata[7] && is_store);

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd && !mem_wr);
endmodule

bind hpt_walker hpt_walker_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_store (is_store),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .done     (done)
);

// File: tb/tb_hpt_walker.sv
`timescale 1ns/1ps
module tb_hpt_walker;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [31:0] MASK = 32'h0000_0FC0;

    typedef struct packed {
        logic        found;
        logic [31:0] pte_addr;
        logic [31:0] w1;
        logic [31:0] real_addr;
        logic        revoke;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [27:0] seg_ofs = '0;
    logic [23:0] vsid = '0;
    logic        is_store = 1'b0;
    logic        grant = 1'b0;
    logic        mem_rd, mem_wr, mem_ready;
    logic [31:0] mem_addr, mem_rdata;
    logic [7:0]  mem_wdata;
    logic        done, found, wr_revoke;
    logic [31:0] pte_addr, pte_w0, pte_w1, real_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [0:8191];
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_hist [0:255];
    logic [31:0] wr_addr_hist [0:255];
    logic [7:0]  wr_data_hist [0:255];
    logic [1:0]  lat = 2'd0;
    exp_t        sb_q [$];

    always #10 clk = ~clk;

    hpt_walker dut (
        .clk(clk), .rst_n(rst_n), .req(req), .seg_ofs(seg_ofs), .vsid(vsid),
        .tbl_base(BASE), .tbl_mask(MASK), .is_store(is_store), .grant(grant),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done), .found(found),
        .pte_addr(pte_addr), .pte_w0(pte_w0), .pte_w1(pte_w1), .real_addr(real_addr),
        .wr_revoke(wr_revoke)
    );

    // memory responder with latency 0..2 cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            lat       <= 2'd0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_rd || mem_wr) begin
            if (lat != 2'd0) begin
                lat <= lat - 2'd1;
            end else begin
                mem_ready <= 1'b1;
                lat       <= 2'((rd_cnt + wr_cnt) % 3);
                if (mem_rd) begin
                    mem_rdata <= {mem[mem_addr[12:0]], mem[mem_addr[12:0] + 13'd1],
                                  mem[mem_addr[12:0] + 13'd2], mem[mem_addr[12:0] + 13'd3]};
                    rd_hist[rd_cnt % 256] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end else begin
                    wr_addr_hist[wr_cnt % 256] <= mem_addr;
                    wr_data_hist[wr_cnt % 256] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R1", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(found == e.found, "R6", "found", 32'(found), 32'(e.found));
                if (e.found) begin
                    chk(pte_addr == e.pte_addr, "R11", "pte_addr", pte_addr, e.pte_addr);
                    chk(pte_w1 == e.w1, "R11", "pte_w1", pte_w1, e.w1);
                    chk(real_addr == e.real_addr, "R11", "real_addr", real_addr, e.real_addr);
                    chk(wr_revoke == e.revoke, "R9", "wr_revoke", 32'(wr_revoke), 32'(e.revoke));
                end
            end
        end
    end

    function automatic logic [31:0] grp(input logic [23:0] v, input logic [27:0] o, input bit sec);
        logic [31:0] h;
        h = {8'b0, v} ^ {16'b0, o[27:12]};
        if (sec) h = ~h;
        return BASE + ((h << 6) & MASK);
    endfunction

    function automatic logic [31:0] mk_w0(input bit valid, input logic [23:0] v,
                                          input bit hsel, input logic [5:0] api);
        return {valid, v, hsel, api};
    endfunction

    task automatic put_word(input logic [31:0] a, input logic [31:0] w);
        mem[a[12:0]]         = w[31:24];
        mem[a[12:0] + 13'd1] = w[23:16];
        mem[a[12:0] + 13'd2] = w[15:8];
        mem[a[12:0] + 13'd3] = w[7:0];
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    endtask

    task automatic run(input logic [27:0] o, input logic [23:0] v, input bit st, input bit gr,
                       input exp_t e, input int exp_rd, input int exp_wr,
                       input logic [31:0] exp_first, input bit poke, input string rq);
        int rd0, wr0;
        bit seen;
        @(negedge clk);
        seg_ofs = o; vsid = v; is_store = st; grant = gr;
        rd0 = rd_cnt; wr0 = wr_cnt;
        sb_q.push_back(e);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            req = 1'b1; seg_ofs = o ^ 28'h0F0_0000;
            @(negedge clk);
            req = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen, rq, "done seen", 32'(seen), 32'd1);
        chk(rd_cnt - rd0 == exp_rd, rq, "read count", 32'(rd_cnt - rd0), 32'(exp_rd));
        chk(wr_cnt - wr0 == exp_wr, rq, "write count", 32'(wr_cnt - wr0), 32'(exp_wr));
        chk(rd_hist[rd0 % 256] == exp_first, "R2", "first read address",
            rd_hist[rd0 % 256], exp_first);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] va, vb;
        logic [27:0] oa, ob;
        logic [31:0] pa, sa, pb, ea_;
        exp_t e;
        va = 24'h000123; oa = 28'hABCD123;
        vb = 24'hFFFFFF; ob = 28'h0000456;
        pa = grp(va, oa, 1'b0);
        sa = grp(va, oa, 1'b1);
        pb = grp(vb, ob, 1'b0);
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !found && !mem_rd && !mem_wr, "R1", "reset outputs",
            {28'b0, done, found, mem_rd, mem_wr}, 32'd0);

        // R3 R7 R8: primary hit at entry 3, store, both flags clear
        clear_mem();
        ea_ = pa + 32'd24;
        put_word(ea_, mk_w0(1'b1, va, 1'b0, 6'h2A));
        put_word(ea_ + 4, 32'h5566_7002);
        e = '{1'b1, ea_, 32'h5566_7002, 32'h5566_7123, 1'b0};
        run(oa, va, 1'b1, 1'b1, e, 5, 2, pa, 1'b0, "R3");
        chk(wr_addr_hist[(wr_cnt - 2) % 256] == ea_ + 6, "R7", "ref byte addr",
            wr_addr_hist[(wr_cnt - 2) % 256], ea_ + 6);
        chk(wr_data_hist[(wr_cnt - 2) % 256] == 8'h71, "R7", "ref byte value",
            32'(wr_data_hist[(wr_cnt - 2) % 256]), 32'h71);
        chk(wr_addr_hist[(wr_cnt - 1) % 256] == ea_ + 7, "R8", "chg byte addr",
            wr_addr_hist[(wr_cnt - 1) % 256], ea_ + 7);
        chk(wr_data_hist[(wr_cnt - 1) % 256] == 8'h82, "R8", "chg byte value",
            32'(wr_data_hist[(wr_cnt - 1) % 256]), 32'h82);
        chk(rd_hist[(rd_cnt - 1) % 256] == ea_ + 4, "R5", "word1 read last",
            rd_hist[(rd_cnt - 1) % 256], ea_ + 4);
        chk(rd_hist[(rd_cnt - 2) % 256] == ea_, "R5", "word0 read before word1",
            rd_hist[(rd_cnt - 2) % 256], ea_);

        // R9: load, both clear, group at mask top edge
        clear_mem();
        put_word(pb, mk_w0(1'b1, vb, 1'b0, 6'h00));
        put_word(pb + 4, 32'h1234_5003);
        e = '{1'b1, pb, 32'h1234_5003, 32'h1234_5456, 1'b1};
        run(ob, vb, 1'b0, 1'b1, e, 2, 1, pb, 1'b0, "R9");
        chk(wr_data_hist[(wr_cnt - 1) % 256] == 8'h51, "R7", "ref byte on load",
            32'(wr_data_hist[(wr_cnt - 1) % 256]), 32'h51);
        chk(wr_addr_hist[(wr_cnt - 1) % 256] == pb + 6, "R9", "only ref byte written",
            wr_addr_hist[(wr_cnt - 1) % 256], pb + 6);

        // R8: referenced already set, store, changed clear
        clear_mem();
        put_word(pa, mk_w0(1'b1, va, 1'b0, 6'h2A));
        put_word(pa + 4, 32'h4444_4100);
        e = '{1'b1, pa, 32'h4444_4100, 32'h4444_4123, 1'b0};
        run(oa, va, 1'b1, 1'b1, e, 2, 1, pa, 1'b0, "R8");
        chk(wr_data_hist[(wr_cnt - 1) % 256] == 8'h80 &&
            wr_addr_hist[(wr_cnt - 1) % 256] == pa + 7, "R8", "chg only write",
            32'(wr_data_hist[(wr_cnt - 1) % 256]), 32'h80);

        // R10: grant low, store, both clear, entry 7
        clear_mem();
        put_word(pa + 56, mk_w0(1'b1, va, 1'b0, 6'h2A));
        put_word(pa + 60, 32'h0A0B_C000);
        e = '{1'b1, pa + 56, 32'h0A0B_C000, 32'h0A0B_C123, 1'b0};
        run(oa, va, 1'b1, 1'b0, e, 9, 0, pa, 1'b0, "R10");

        // R11: both flags set, store, entry 5, no writes
        clear_mem();
        put_word(pa + 40, mk_w0(1'b1, va, 1'b0, 6'h2A));
        put_word(pa + 44, 32'h7777_7180);
        e = '{1'b1, pa + 40, 32'h7777_7180, 32'h7777_7123, 1'b0};
        run(oa, va, 1'b1, 1'b1, e, 7, 0, pa, 1'b0, "R11");
        chk(pte_w0 == mk_w0(1'b1, va, 1'b0, 6'h2A), "R11", "pte_w0",
            pte_w0, mk_w0(1'b1, va, 1'b0, 6'h2A));

        // R4: secondary hit behind decoys
        clear_mem();
        put_word(pa, mk_w0(1'b1, va, 1'b1, 6'h2A));
        put_word(pa + 8, mk_w0(1'b1, va, 1'b0, 6'h2B));
        put_word(sa, mk_w0(1'b1, va, 1'b0, 6'h2A));
        put_word(sa + 16, mk_w0(1'b1, va, 1'b1, 6'h2A));
        put_word(sa + 20, 32'h3333_3100);
        e = '{1'b1, sa + 16, 32'h3333_3100, 32'h3333_3123, 1'b1};
        run(oa, va, 1'b0, 1'b1, e, 12, 0, pa, 1'b0, "R4");
        chk(rd_hist[(rd_cnt - 4) % 256] == sa, "R4", "secondary group start",
            rd_hist[(rd_cnt - 4) % 256], sa);

        // R6 R1: full miss with an invalid look-alike and a req during the walk
        clear_mem();
        put_word(pa, mk_w0(1'b0, va, 1'b0, 6'h2A));
        e = '{1'b0, 32'h0, 32'h0, 32'h0, 1'b0};
        run(oa, va, 1'b0, 1'b1, e, 16, 0, pa, 1'b1, "R6");
        chk(rd_hist[(rd_cnt - 1) % 256] == sa + 56, "R6", "last read secondary entry 7",
            rd_hist[(rd_cnt - 1) % 256], sa + 56);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (done || mem_rd || mem_wr) quiet = 1'b0;
            end
            chk(quiet, "R1", "busy req ignored", 32'(quiet), 32'd1);
        end
        chk(sb_q.size() == 0, "R1", "scoreboard drained", 32'(sb_q.size()), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule